// File: doc/BRIEF.md
# Contact Debounce Delay Chain with Edge One-Shot

This block filters one raw, active-low contact line through a chain of identical debounce integrators. Each integrator passes a new level only after its input has disagreed with its output for a set number of consecutive clock samples. The clean output of each integrator drives the next one, so the chain acts as a tapped delay line. Every tap repeats the previous tap shifted by exactly one filter window. All taps are brought out, which gives a set of staggered timing signals from a single switch.

The first two taps also feed a one-shot. Each tap is treated as active low. One tap is inverted and the two are combined in a NOR, which gives a pulse exactly one filter window long. A select input picks which tap is inverted, and so whether the pulse marks the contact closing (line going low) or the contact opening (line going high). The pulse is registered, so it changes only at the clock edge. No amount of bounce on the raw line produces more than one pulse per accepted transition.

Top module: `contact_pulse_chain`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, every bit of taps_o is 1 and pulse_o is 0, whatever contact_ni and edge_sel_i do.
- R2: taps_o[0] takes a new level only after contact_ni has differed from it on SAMPLES consecutive rising edges, and it changes on the last of those edges. A shorter run of the opposite level leaves taps_o[0] unchanged.
- R3: For every tap k above 0, taps_o[k] equals taps_o[k-1] delayed by exactly SAMPLES clock cycles.
- R4: With edge_sel_i = 0 (closing), pulse_o goes high one cycle after taps_o[0] falls and stays high for exactly SAMPLES cycles.
- R5: With edge_sel_i = 1 (opening), pulse_o goes high one cycle after taps_o[0] rises and stays high for exactly SAMPLES cycles.
- R6: Each accepted transition of the selected direction produces exactly one pulse, however the raw line bounced before settling. A transition of the other direction produces none.
- R7: A change of edge_sel_i while taps_o[0] and taps_o[1] agree produces no pulse. The selector is expected to change only then.
- R8: Once a tap has taken a new level, it holds that level for at least SAMPLES cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock; every stage and the one-shot use its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| contact_ni | input | 1 | Raw contact line, low when the contact is closed |
| edge_sel_i | input | 1 | 0: pulse on closing, 1: pulse on opening |
| taps_o | output | TAPS | Clean delayed copies of the line; bit 0 is the first stage |
| pulse_o | output | 1 | Registered one-shot, high for SAMPLES cycles |

## Verification
On every cycle the embedded properties confirm that no tap flips before it has held its level for a full window, that a tap flips only after its input disagreed with it, that a pulse never outlasts the window and ends at exactly its length, and that a pulse starts only right after the first tap moved. Whether a tap moves on exactly the right edge, whether bounce shorter than the window is rejected, and whether the right direction gets the one and only pulse can only be shown by the bench. It does this by replaying clean, bouncy, three-sample and four-sample runs under both selector settings against an event scoreboard.

// File: rtl/contact_pulse_chain_pkg.sv
package contact_pulse_chain_pkg;

  typedef enum logic {
    EDGE_MAKE  = 1'b0,
    EDGE_BREAK = 1'b1
  } edge_sel_e;

  localparam int unsigned DEF_SAMPLES = 4;
  localparam int unsigned DEF_TAPS    = 6;

endpackage

// File: rtl/cpc_stage.sv
module cpc_stage #(
  parameter int unsigned SAMPLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic q_o
);
  localparam int unsigned CNT_W = $clog2(SAMPLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLES - 1);
  localparam int unsigned HLD_W = $clog2(SAMPLES + 1);
  localparam logic [HLD_W-1:0] HLD_SAT = HLD_W'(SAMPLES);

  logic [CNT_W-1:0] cnt_q;
  logic             differ;

  assign differ = in_i ^ q_o;

  // integrate up while input disagrees, restart on any agreeing sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q_o   <= 1'b1;
    end else if (!differ) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      q_o   <= in_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // observer of the output level only, independent of the integrator
  logic             q_seen_q;
  logic [HLD_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_seen_q <= 1'b1;
      hold_q   <= '0;
    end else begin
      q_seen_q <= q_o;
      if (q_o != q_seen_q)       hold_q <= '0;
      else if (hold_q != HLD_SAT) hold_q <= hold_q + 1'b1;
    end
  end

  // R8
  min_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(q_o) |-> (hold_q >= HLD_W'(SAMPLES - 1)));

  // R2
  flip_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(q_o) |-> ($past(in_i) != $past(q_o)));

endmodule

// File: rtl/cpc_shot.sv
module cpc_shot
  import contact_pulse_chain_pkg::*;
#(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lead_i,
  input  logic lag_i,
  input  logic edge_sel_i,
  output logic pulse_o
);
  localparam int unsigned RUN_W = $clog2(LEN + 1);
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(LEN);

  logic fire;

  // both taps active low; the inverted one sets the direction
  always_comb begin
    case (edge_sel_e'(edge_sel_i))
      EDGE_MAKE:  fire = ~(lead_i | ~lag_i);
      EDGE_BREAK: fire = ~(~lead_i | lag_i);
      default:    fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= 1'b0;
    else         pulse_o <= fire;
  end

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               run_q <= '0;
    else if (!pulse_o)         run_q <= '0;
    else if (run_q != RUN_SAT) run_q <= run_q + 1'b1;
  end

  // R4 R5
  pulse_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> (run_q < RUN_W'(LEN)));

  // R4 R5
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pulse_o) && $stable(edge_sel_i)) |-> ($past(run_q) == RUN_W'(LEN - 1)));

  // R6
  pulse_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pulse_o) && ($past(edge_sel_i) == $past(edge_sel_i, 2)))
      |-> ($past(lead_i) != $past(lead_i, 2)));

endmodule

// File: rtl/contact_pulse_chain.sv
module contact_pulse_chain
  import contact_pulse_chain_pkg::*;
#(
  parameter int unsigned SAMPLES = DEF_SAMPLES,
  parameter int unsigned TAPS    = DEF_TAPS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            contact_ni,
  input  logic            edge_sel_i,
  output logic [TAPS-1:0] taps_o,
  output logic            pulse_o
);
  logic [TAPS-1:0] tap;

  for (genvar g = 0; g < TAPS; g++) begin : g_stage
    logic stage_in;
    if (g == 0) begin : g_head
      assign stage_in = contact_ni;
    end else begin : g_link
      assign stage_in = tap[g-1];
    end
    cpc_stage #(.SAMPLES(SAMPLES)) i_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .in_i   (stage_in),
      .q_o    (tap[g])
    );
  end

  cpc_shot #(.LEN(SAMPLES)) i_shot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lead_i     (tap[0]),
    .lag_i      (tap[1]),
    .edge_sel_i (edge_sel_i),
    .pulse_o    (pulse_o)
  );

  assign taps_o = tap;

endmodule

// File: tb/test_contact_pulse_chain.sv
module test_contact_pulse_chain;
  localparam int unsigned SAMPLES = 4;
  localparam int unsigned TAPS    = 6;
  localparam int unsigned QUIET   = SAMPLES * TAPS + 3 * SAMPLES;

  typedef struct {
    int   cyc;
    int   idx;
    logic val;
  } ev_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            contact = 1'b1;
  logic            sel = 1'b0;
  logic [TAPS-1:0] taps;
  logic            pulse;

  int   cyc = 0;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;
  logic line_lvl = 1'b1;
  ev_t  sb_q[$];
  logic [TAPS-1:0] exp_taps = '1;
  logic            exp_pulse = 1'b0;

  contact_pulse_chain #(.SAMPLES(SAMPLES), .TAPS(TAPS)) i_contact_pulse_chain (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .contact_ni (contact),
    .edge_sel_i (sel),
    .taps_o     (taps),
    .pulse_o    (pulse)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: got %0h expected %0h", tag, cyc, got, exp);
    end
  endtask

  // driver: hold lvl for 'hold' sampling edges, push the expected tap and pulse events
  task automatic drive_run(input logic lvl, input int hold);
    int n;
    @(negedge clk);
    contact = lvl;
    n = cyc + 1;
    if (lvl != line_lvl && hold >= int'(SAMPLES)) begin
      for (int k = 0; k < int'(TAPS); k++)
        sb_q.push_back('{n + int'(SAMPLES) - 1 + int'(SAMPLES) * k, k, lvl});
      if ((sel == 1'b0 && lvl == 1'b0) || (sel == 1'b1 && lvl == 1'b1)) begin
        sb_q.push_back('{n + int'(SAMPLES), int'(TAPS), 1'b1});
        sb_q.push_back('{n + 2 * int'(SAMPLES), int'(TAPS), 1'b0});
      end
      line_lvl = lvl;
    end
    repeat (hold - 1) @(negedge clk);
  endtask

  task automatic set_sel(input logic v);
    @(negedge clk);
    sel = v;
  endtask

  // monitor: apply due events, compare outputs every cycle
  always @(negedge clk) begin
    int idx;
    if (rst_n) begin
      idx = 0;
      while (idx < sb_q.size()) begin
        if (sb_q[idx].cyc == cyc) begin
          if (sb_q[idx].idx == int'(TAPS)) exp_pulse = sb_q[idx].val;
          else exp_taps[sb_q[idx].idx] = sb_q[idx].val;
          sb_q.delete(idx);
        end else if (sb_q[idx].cyc < cyc) begin
          check(1'b0, "R3 stale event", sb_q[idx].cyc, cyc);
          sb_q.delete(idx);
        end else begin
          idx++;
        end
      end
      // R2 R3 R8: tap timing, bounce rejection, minimum hold
      check(taps == exp_taps, "R2/R3/R8 taps", int'(taps), int'(exp_taps));
      // R4 R5 R6 R7: pulse position, length, uniqueness, selector
      check(pulse == exp_pulse, "R4/R5/R6/R7 pulse", int'(pulse), int'(exp_pulse));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at cycle %0d: got hung expected finish", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset holds idle levels even with the line and selector moving
    repeat (2) @(negedge clk);
    contact = 1'b0;
    sel = 1'b1;
    repeat (6) @(negedge clk);
    check(taps == '1, "R1 reset taps", int'(taps), int'((1 << TAPS) - 1));
    check(pulse == 1'b0, "R1 reset pulse", int'(pulse), 0);
    contact = 1'b1;
    sel = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(taps == '1, "R1 after release taps", int'(taps), int'((1 << TAPS) - 1));
    check(pulse == 1'b0, "R1 after release pulse", int'(pulse), 0);
    repeat (4) @(negedge clk);

    // R4 R6: clean close gives one pulse, clean open gives none
    drive_run(1'b0, QUIET);
    drive_run(1'b1, QUIET);

    // R2 R6: bouncy close and open, still one pulse
    drive_run(1'b0, 2);
    drive_run(1'b1, 1);
    drive_run(1'b0, 3);
    drive_run(1'b1, 2);
    drive_run(1'b0, QUIET);
    drive_run(1'b1, 1);
    drive_run(1'b0, 2);
    drive_run(1'b1, QUIET);

    // R7: selector toggles while idle
    set_sel(1'b1);
    repeat (3) @(negedge clk);
    set_sel(1'b0);
    repeat (3) @(negedge clk);
    set_sel(1'b1);
    repeat (10) @(negedge clk);

    // R5 R6: break selected, bouncy close gives none, bouncy open gives one
    drive_run(1'b0, 1);
    drive_run(1'b1, 3);
    drive_run(1'b0, QUIET);
    drive_run(1'b1, 2);
    drive_run(1'b0, 1);
    drive_run(1'b1, QUIET);

    // R2 R8 boundary: three samples rejected, four accepted and held
    set_sel(1'b0);
    repeat (4) @(negedge clk);
    drive_run(1'b0, int'(SAMPLES) - 1);
    drive_run(1'b1, 10);
    drive_run(1'b0, int'(SAMPLES));
    drive_run(1'b1, QUIET);

    // R5 boundary with break selected
    set_sel(1'b1);
    repeat (4) @(negedge clk);
    drive_run(1'b0, int'(SAMPLES));
    drive_run(1'b1, QUIET);

    repeat (8) @(negedge clk);
    check(sb_q.size() == 0, "R3 scoreboard drained", sb_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule